// File: doc/BRIEF.md
# Audio bit and frame clock generator

This block produces the two timing clocks an audio serial port needs: a bit clock and a left/right frame clock. Both are derived from the master clock that runs the block. The bit clock is the master clock divided by 2 or by 4. The frame clock is the bit clock divided by 32, 64 or 128, and it has a 50% duty cycle. Each clock comes with a one-cycle strobe that marks every transition the dividers make. All outputs are registers clocked by the master clock.

The settings come from a 32-bit configuration word. It carries an enable, a bit-clock divisor select, a frame divisor select, a polarity flag and an override flag. A second, 5-bit mode input comes from the audio interface and carries the same enable and divisor settings. The override flag in the configuration word picks which of the two sources is in control. The polarity flag picks which bit-clock edge may move the frame clock. When the generator is enabled, both clocks start low, and the frame clock begins in its left-channel half.

Top module: `acg_audio_clkgen`

## Requirements
- R1: While `rst_n` is low, `bclk`, `bclk_tgl`, `lrclk` and `lrclk_tgl` are all 0.
- R2: When the effective bit-clock select is 0, `bclk` toggles on every master-clock edge, which is division by 2. When the select is 1, `bclk` toggles on every second edge, which is division by 4. In `cfg_word` this select is bit 16.
- R3: The frame clock stays in each half for 16, 32 or 64 bit-clock periods. The effective frame code sets the length: 0 gives 16, 1 gives 32 and 2 gives 64. In `cfg_word` the frame code is bits 18:17.
- R4: Frame code 3 is illegal. With code 3, `lrclk` is held at 0 and `lrclk_tgl` stays 0, while `bclk` keeps running.
- R5: When the effective enable is 0, all four outputs are 0 from the next cycle onward. In `cfg_word` the enable is bit 31.
- R6: When the effective polarity is 1, `lrclk` changes only in the cycle where `bclk` falls. When the polarity is 0, `lrclk` changes only in the cycle where `bclk` rises. In `cfg_word` the polarity is bit 19.
- R7: When `cfg_word` bit 29 is 1, the enable, polarity, frame code and bit-clock select are taken from `cfg_word`. When bit 29 is 0, they are taken from `iface_mode`, whose layout is [4] enable, [3] polarity, [2:1] frame code and [0] bit-clock select.
- R8: After the enable goes from 0 to 1, both clocks start low. The first `bclk` rise comes after one bit-clock half period. The first `lrclk` change comes on the 16×2^code-th selected bit-clock edge.
- R9: `bclk_tgl` and `lrclk_tgl` are high for exactly one cycle with each transition made by a divider, in the same cycle the new level appears. A level forced low by disable or by the illegal frame code raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word (enable, override, polarity, frame code, bit-clock select) |
| iface_mode | input | 5 | Settings from the audio interface, used when override is clear |
| bclk | output | 1 | Bit clock |
| bclk_tgl | output | 1 | Strobe for each bit-clock transition |
| lrclk | output | 1 | Left/right frame clock, low half first |
| lrclk_tgl | output | 1 | Strobe for each frame-clock transition |

## Verification
The bit-clock transition that completes a frame half and the frame-clock transition it causes fall in the same master cycle. A settings change can land in that same cycle. The bench provokes this by switching the bit-clock divisor and the polarity on the exact edge where a frame change is due. A behavioural reference model, compared on every clock, then judges whether the frame clock moves on the edge the new polarity requires, and with the counts the new divisor implies.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int CFG_W    = 32;
  localparam int EN_POS   = 31;
  localparam int OVR_POS  = 29;
  localparam int POL_POS  = 19;
  localparam int FDIV_LSB = 17;
  localparam int BDIV_POS = 16;

  typedef struct packed {
    logic       en;
    logic       pol;
    logic [1:0] fsel;
    logic       bsel;
  } acg_mode_t;

  // master cycles per bit-clock half period
  function automatic int unsigned bclk_half(input logic bsel,
                                            input int unsigned fast_half,
                                            input int unsigned slow_half);
    return bsel ? slow_half : fast_half;
  endfunction

  // bit-clock periods per frame half
  function automatic int unsigned lr_half(input logic [1:0] code,
                                          input int unsigned base_half);
    return base_half << code;
  endfunction

  function automatic logic lr_code_ok(input logic [1:0] code,
                                      input int unsigned ncodes);
    return int'(code) < int'(ncodes);
  endfunction
endpackage

// File: rtl/acg_mode_sel.sv
module acg_mode_sel
  import acg_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [4:0]       iface_mode,
  output acg_mode_t        eff
);
  acg_mode_t from_cfg;
  acg_mode_t from_if;

  always_comb begin
    from_cfg.en   = cfg_word[EN_POS];
    from_cfg.pol  = cfg_word[POL_POS];
    from_cfg.fsel = cfg_word[FDIV_LSB +: 2];
    from_cfg.bsel = cfg_word[BDIV_POS];
    from_if       = acg_mode_t'(iface_mode);
    eff           = cfg_word[OVR_POS] ? from_cfg : from_if;
  end
endmodule

// File: rtl/acg_bclk_div.sv
module acg_bclk_div
  import acg_pkg::*;
#(
  parameter int unsigned FAST_HALF = 1,
  parameter int unsigned SLOW_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bsel,
  output logic tick_now,
  output logic bclk,
  output logic bclk_tgl
);
  localparam int CW = $clog2(SLOW_HALF + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;

  assign half_m1  = CW'(bclk_half(bsel, FAST_HALF, SLOW_HALF) - 1);
  assign tick_now = en && (cnt >= half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      bclk     <= 1'b0;
      bclk_tgl <= 1'b0;
    end else if (!en) begin
      cnt      <= '0;
      bclk     <= 1'b0;
      bclk_tgl <= 1'b0;
    end else if (tick_now) begin
      cnt      <= '0;
      bclk     <= ~bclk;
      bclk_tgl <= 1'b1;
    end else begin
      cnt      <= cnt + 1'b1;
      bclk_tgl <= 1'b0;
    end
  end
endmodule

// File: rtl/acg_lrclk_div.sv
module acg_lrclk_div
  import acg_pkg::*;
#(
  parameter int unsigned BASE_HALF = 16,
  parameter int unsigned CODES     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pol,
  input  logic [1:0] fsel,
  input  logic       btick,
  input  logic       bclk_cur,
  output logic       frame_now,
  output logic       lrclk,
  output logic       lrclk_tgl
);
  localparam int unsigned MAX_HALF = BASE_HALF << (CODES - 1);
  localparam int CW = $clog2(MAX_HALF);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;
  logic          legal;
  logic          sel_edge;
  logic          run;

  assign legal     = lr_code_ok(fsel, CODES);
  assign half_m1   = CW'(lr_half(fsel, BASE_HALF) - 1);
  // bclk high now and toggling means a falling edge
  assign sel_edge  = btick && (pol ? bclk_cur : !bclk_cur);
  assign run       = en && legal;
  assign frame_now = run && sel_edge && (cnt >= half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      lrclk     <= 1'b0;
      lrclk_tgl <= 1'b0;
    end else if (!run) begin
      cnt       <= '0;
      lrclk     <= 1'b0;
      lrclk_tgl <= 1'b0;
    end else if (frame_now) begin
      cnt       <= '0;
      lrclk     <= ~lrclk;
      lrclk_tgl <= 1'b1;
    end else begin
      if (sel_edge) cnt <= cnt + 1'b1;
      lrclk_tgl <= 1'b0;
    end
  end
endmodule

// File: rtl/acg_audio_clkgen.sv
module acg_audio_clkgen
  import acg_pkg::*;
#(
  parameter int unsigned BCLK_FAST_HALF = 1,
  parameter int unsigned BCLK_SLOW_HALF = 2,
  parameter int unsigned LR_BASE_HALF   = 16,
  parameter int unsigned LR_CODES       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [4:0]       iface_mode,
  output logic             bclk,
  output logic             bclk_tgl,
  output logic             lrclk,
  output logic             lrclk_tgl
);
  acg_mode_t  eff;
  logic       eff_en;
  logic       eff_pol;
  logic [1:0] eff_fsel;
  logic       eff_bsel;
  logic       btick;
  logic       frame_now;

  acg_mode_sel u_sel (
    .cfg_word  (cfg_word),
    .iface_mode(iface_mode),
    .eff       (eff)
  );

  assign eff_en   = eff.en;
  assign eff_pol  = eff.pol;
  assign eff_fsel = eff.fsel;
  assign eff_bsel = eff.bsel;

  acg_bclk_div #(
    .FAST_HALF(BCLK_FAST_HALF),
    .SLOW_HALF(BCLK_SLOW_HALF)
  ) u_bdiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (eff_en),
    .bsel    (eff_bsel),
    .tick_now(btick),
    .bclk    (bclk),
    .bclk_tgl(bclk_tgl)
  );

  acg_lrclk_div #(
    .BASE_HALF(LR_BASE_HALF),
    .CODES    (LR_CODES)
  ) u_lrdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (eff_en),
    .pol      (eff_pol),
    .fsel     (eff_fsel),
    .btick    (btick),
    .bclk_cur (bclk),
    .frame_now(frame_now),
    .lrclk    (lrclk),
    .lrclk_tgl(lrclk_tgl)
  );
endmodule

// File: rtl/acg_audio_clkgen_chk.sv
module acg_audio_clkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eff_en,
  input logic       eff_pol,
  input logic [1:0] eff_fsel,
  input logic       eff_bsel,
  input logic       bclk,
  input logic       bclk_tgl,
  input logic       lrclk,
  input logic       lrclk_tgl
);
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_en |=> (!bclk && !lrclk && !bclk_tgl && !lrclk_tgl));

  p_fast_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_en && !eff_bsel) |=> bclk_tgl);

  p_slow_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_en && eff_bsel && bclk_tgl) |=> !bclk_tgl);

  p_illegal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_fsel == 2'd3) |=> (!lrclk && !lrclk_tgl));

  p_fall_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_en && eff_pol) |=> (!lrclk_tgl || $fell(bclk)));

  p_rise_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_en && !eff_pol) |=> (!lrclk_tgl || $rose(bclk)));

  p_bstrobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tgl |-> (bclk != $past(bclk)));

  p_lrstrobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lrclk_tgl |-> (lrclk != $past(lrclk)));
endmodule

bind acg_audio_clkgen acg_audio_clkgen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eff_en   (eff_en),
  .eff_pol  (eff_pol),
  .eff_fsel (eff_fsel),
  .eff_bsel (eff_bsel),
  .bclk     (bclk),
  .bclk_tgl (bclk_tgl),
  .lrclk    (lrclk),
  .lrclk_tgl(lrclk_tgl)
);

// File: tb/acg_audio_clkgen_tb.sv
module acg_audio_clkgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [4:0]  iface_mode = '0;
  logic        bclk, bclk_tgl, lrclk, lrclk_tgl;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  // reference model state
  bit m_b, m_bt, m_l, m_lt;
  int m_bc, m_lc;

  always #10 clk = ~clk;

  acg_audio_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .iface_mode(iface_mode),
    .bclk(bclk), .bclk_tgl(bclk_tgl), .lrclk(lrclk), .lrclk_tgl(lrclk_tgl)
  );

  function automatic logic [31:0] mk_cfg(bit en, bit ovr, bit pol, int fsel, bit bsel);
    logic [31:0] w = '0;
    w[31] = en; w[29] = ovr; w[19] = pol;
    w[18:17] = fsel[1:0]; w[16] = bsel;
    return w;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_b = 0; m_bt = 0; m_l = 0; m_lt = 0; m_bc = 0; m_lc = 0;
    end else begin
      bit en, pol, bs, flip, chosen;
      int fs, hb, hl;
      if (cfg_word[29]) begin
        en = cfg_word[31]; pol = cfg_word[19]; fs = int'(cfg_word[18:17]); bs = cfg_word[16];
      end else begin
        en = iface_mode[4]; pol = iface_mode[3]; fs = int'(iface_mode[2:1]); bs = iface_mode[0];
      end
      hb = bs ? 2 : 1;
      hl = 16 * (2 ** fs);
      if (!en) begin
        m_b = 0; m_bt = 0; m_l = 0; m_lt = 0; m_bc = 0; m_lc = 0;
      end else begin
        flip = (m_bc + 1 >= hb);
        m_bc = flip ? 0 : m_bc + 1;
        chosen = flip && (pol ? m_b : !m_b);
        m_bt = flip;
        if (flip) m_b = !m_b;
        m_lt = 0;
        if (fs == 3) begin
          m_l = 0; m_lc = 0;
        end else if (chosen) begin
          if (m_lc + 1 >= hl) begin m_l = !m_l; m_lc = 0; m_lt = 1; end
          else m_lc = m_lc + 1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(bclk == m_b, cur_req, "bclk", int'(bclk), int'(m_b));
      check(lrclk == m_l, cur_req, "lrclk", int'(lrclk), int'(m_l));
      check(bclk_tgl == m_bt, "R9", "bclk_tgl", int'(bclk_tgl), int'(m_bt));
      check(lrclk_tgl == m_lt, "R9", "lrclk_tgl", int'(lrclk_tgl), int'(m_lt));
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_tgl(int n, output int bt, output int lt);
    bt = 0; lt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bt += int'(bclk_tgl);
      lt += int'(lrclk_tgl);
    end
  endtask

  // enable from idle and time the first frame change (R3, R6, R8)
  task automatic first_frame(bit bsel, int fsel, bit pol, string req);
    int cnt, hb, hl, exp;
    @(negedge clk) cfg_word = mk_cfg(0, 1, pol, fsel, bsel);
    cycles(3);
    cfg_word = mk_cfg(1, 1, pol, fsel, bsel);
    hb = bsel ? 2 : 1;
    hl = 16 * (2 ** fsel);
    exp = pol ? 2 * hl * hb : (2 * hl - 1) * hb;
    cnt = 0;
    @(negedge clk); cnt = 1;
    check(lrclk == 1'b0, "R8", "lrclk after enable", int'(lrclk), 0);
    check(bclk == (hb == 1), "R8", "bclk after enable", int'(bclk), int'(hb == 1));
    while (!lrclk_tgl && cnt < 2000) begin
      @(negedge clk); cnt++;
    end
    check(cnt == exp, req, "cycles to first frame change", cnt, exp);
    check(lrclk == 1'b1, "R8", "lrclk after first change", int'(lrclk), 1);
    cycles(300);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int bt, lt;
    cycles(4);
    check(!bclk && !lrclk && !bclk_tgl && !lrclk_tgl, "R1", "outputs in reset",
          int'({bclk, bclk_tgl, lrclk, lrclk_tgl}), 0);
    @(negedge clk) rst_n = 1'b1;
    cmp_on = 1'b1;
    cycles(2);
    check(!bclk && !lrclk, "R1", "outputs idle after reset", int'({bclk, lrclk}), 0);

    cur_req = "R3"; first_frame(0, 0, 0, "R3");
    cur_req = "R6"; first_frame(1, 0, 1, "R6");
    cur_req = "R6"; first_frame(0, 1, 1, "R6");
    cur_req = "R3"; first_frame(1, 1, 0, "R3");
    cur_req = "R3"; first_frame(0, 2, 0, "R3");
    cur_req = "R6"; first_frame(1, 2, 1, "R6");

    // R2: divisor rates
    cur_req = "R2";
    @(negedge clk) cfg_word = mk_cfg(1, 1, 0, 0, 0);
    cycles(4);
    count_tgl(40, bt, lt);
    check(bt == 40, "R2", "divide-by-2 toggles in 40", bt, 40);
    @(negedge clk) cfg_word = mk_cfg(1, 1, 0, 0, 1);
    cycles(4);
    count_tgl(40, bt, lt);
    check(bt == 20, "R2", "divide-by-4 toggles in 40", bt, 20);

    // settings change landing on a frame edge
    @(negedge clk) cfg_word = mk_cfg(1, 1, 0, 0, 0);
    while (!lrclk_tgl) @(negedge clk);
    cycles(31);
    cfg_word = mk_cfg(1, 1, 1, 0, 1);
    cycles(400);

    // R4: illegal frame code
    cur_req = "R4";
    @(negedge clk) cfg_word = mk_cfg(1, 1, 0, 3, 0);
    count_tgl(300, bt, lt);
    check(lt == 0, "R4", "frame toggles with code 3", lt, 0);
    check(lrclk == 1'b0, "R4", "lrclk with code 3", int'(lrclk), 0);
    check(bt == 300, "R4", "bclk keeps running", bt, 300);

    // R5: disable mid-run
    cur_req = "R5";
    @(negedge clk) cfg_word = mk_cfg(1, 1, 0, 0, 0);
    cycles(45);
    cfg_word = mk_cfg(0, 1, 0, 0, 0);
    count_tgl(20, bt, lt);
    check(bt + lt == 0, "R5", "strobes while disabled", bt + lt, 0);
    check(!bclk && !lrclk, "R5", "clocks while disabled", int'({bclk, lrclk}), 0);

    // R7: override selection
    cur_req = "R7";
    @(negedge clk) begin
      cfg_word = mk_cfg(0, 0, 0, 0, 1);
      iface_mode = 5'b1_0_00_0;
    end
    cycles(4);
    count_tgl(20, bt, lt);
    check(bt == 20, "R7", "interface settings in control", bt, 20);
    @(negedge clk) begin
      cfg_word = mk_cfg(1, 0, 0, 0, 1);
      iface_mode = 5'b0_0_00_0;
    end
    count_tgl(20, bt, lt);
    check(bt == 0, "R7", "interface disable obeyed", bt, 0);
    @(negedge clk) begin
      cfg_word = mk_cfg(1, 1, 0, 0, 1);
      iface_mode = 5'b1_0_00_0;
    end
    cycles(4);
    count_tgl(20, bt, lt);
    check(bt == 10, "R7", "register settings take priority", bt, 10);
    cycles(200);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule